// File: doc/BRIEF.md
# Clock Start Reset Sequencer

This block orders the resets that follow a clock-start request from the management port. It also runs a core-only flush reset when the reset command asks for one. A configuration input says whether the clock comes from an on-chip PLL or an off-chip one.

**On-chip PLL.** The block first checks that the PLL has already been programmed. It then takes the PLL out of reset and waits for lock. After that it drives the fast-domain logic reset and then the core flush reset.

**Off-chip PLL.** The PLL stage is skipped. The block goes straight to the fast-domain reset and then the flush reset.

**Flush requests.** A flush request touches only the core flush output. The management, clock-generation, reset and self-test logic is never reset by this block's flush.

**Stage lengths.** The fast-domain reset and the flush reset each last a number of cycles given by an input. A value of zero selects the default length.

**Outcome flags.** Lock that never arrives, or a start without a programmed PLL, leaves the block in an error state. A one-cycle done pulse marks a sequence that completed.

Top module: `clkstart_rst_seq`

## Requirements
- R1: With `int_pll_sel`=1 and `pll_programmed`=1, a `start_req` accepted at edge k clears `pll_rst` at edge k, and `busy` rises. `fast_rst` stays low until `pll_lock` is sampled high. It rises at that same edge.
- R2: `fast_rst` stays high for exactly its stage length. `core_flush` goes high on the edge where `fast_rst` falls and stays high for its own stage length. The two are never high together.
- R3: With `int_pll_sel`=0, an accepted `start_req` raises `fast_rst` at the next edge. `pll_rst` keeps its value for the whole sequence.
- R4: With `int_pll_sel`=1 and `pll_programmed`=0, an accepted `start_req` raises `err` at the next edge. `busy`, `fast_rst` and `core_flush` stay low, and `pll_rst` is unchanged.
- R5: A `flush_req` accepted while idle raises `core_flush` at the next edge for the flush length. `fast_rst` stays low and `pll_rst` is unchanged.
- R6: A length input of 0 selects DEF_LEN cycles (16 by default). Any other value N gives N cycles.
- R7: In the lock wait, if `pll_lock` is not seen within LOCK_TO cycles, `err` rises. `pll_rst` is set back to 1 and `busy` falls.
- R8: `start_req` and `flush_req` that arrive while `busy` is high are ignored. The running stage lengths do not change, and nothing starts after the sequence ends.
- R9: `done` is high for exactly one cycle, in the first cycle back in idle after a completed flush stage.
- R10: While `err` is high, requests are accepted as in idle. An accepted request clears `err`. When `start_req` and `flush_req` arrive together, the start wins.
- R11: After reset, `pll_rst`=1 and `fast_rst`, `core_flush`, `busy`, `err` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_pll_sel | input | 1 | 1 = on-chip PLL, 0 = off-chip PLL |
| pll_programmed | input | 1 | On-chip PLL register already programmed |
| pll_lock | input | 1 | PLL lock indication |
| start_req | input | 1 | Clock-start request pulse |
| flush_req | input | 1 | Flush-reset request pulse |
| fast_len | input | LEN_W | Fast-domain reset length, 0 = default |
| flush_len | input | LEN_W | Flush reset length, 0 = default |
| pll_rst | output | 1 | On-chip PLL reset, active high |
| fast_rst | output | 1 | Fast-domain logic reset, active high |
| core_flush | output | 1 | Core flush reset, active high |
| busy | output | 1 | A sequence is running |
| err | output | 1 | Sequence ended in error |
| done | output | 1 | One-cycle completion pulse |

## Verification
Inputs change on the falling clock edge and outputs are read on the falling edge. This leaves half a cycle on each side of the sampling edge.

A request held across one rising edge shows its first effect at the very next falling edge: the cleared `pll_rst`, a risen `fast_rst`, `core_flush` or `err`. Lock sampled at an edge raises `fast_rst` by the following falling edge.

Stage lengths are measured by counting consecutive falling edges at which the output is high. The result must equal the programmed or default length exactly. `done` is read at the falling edge right after `core_flush` drops, and again one cycle later to confirm that it lasts one cycle.

// File: rtl/seq_pkg.sv
// Shared types for the clock-start reset sequencer.
// Assumes: nothing beyond the IEEE 1800-2017 package rules.
package seq_pkg;

    // Sequencer states: idle, wait for PLL lock, fast reset, core flush, error.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PLLWAIT = 3'd1,
        ST_FAST    = 3'd2,
        ST_FLUSH   = 3'd3,
        ST_ERR     = 3'd4
    } seq_state_t;

endpackage

// File: rtl/seq_timer.sv
// Loadable down-counter shared by all timed stages of the sequencer.
// What it does: on load it takes load_val, otherwise it counts down to 0 and holds there.
// Assumes: the caller loads (length - 1), so a stage lasts 'length' cycles ending when zero is seen.
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Count register: load, decrement toward zero, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    // Zero flag used by the controller to end a stage.
    always_comb zero = (cnt == '0);

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));                     // R2
    AST_TMR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));  // R6

endmodule

// File: rtl/seq_ctrl.sv
// Control FSM of the clock-start reset sequencer.
// What it does: accepts start/flush requests when idle or in error, steps through the
// PLL release, lock wait, fast reset and flush stages, and holds the PLL reset register.
// Assumes: the timer zero flag reflects the value loaded at stage entry; requests are pulses.
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int DEF_LEN = 16,
    parameter int LOCK_TO = 64,
    parameter int TMR_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_pll_sel,
    input  logic             pll_programmed,
    input  logic             pll_lock,
    input  logic             start_req,
    input  logic             flush_req,
    input  logic [LEN_W-1:0] fast_len,
    input  logic [LEN_W-1:0] flush_len,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             pll_rst,
    output logic             fast_rst,
    output logic             core_flush,
    output logic             busy,
    output logic             err,
    output logic             done
);

    seq_state_t       st, st_nx;
    logic             accept;
    logic             pll_release, pll_reassert, done_set;
    logic [TMR_W-1:0] fast_ld, flush_ld;

    // Effective stage lengths minus one: zero on the input selects the default.
    always_comb begin
        fast_ld  = (fast_len  == '0) ? TMR_W'(DEF_LEN - 1) : TMR_W'(fast_len)  - TMR_W'(1);
        flush_ld = (flush_len == '0) ? TMR_W'(DEF_LEN - 1) : TMR_W'(flush_len) - TMR_W'(1);
    end

    // Requests are only taken while no sequence is running.
    always_comb accept = (st == ST_IDLE) || (st == ST_ERR);

    // Next-state, timer load and PLL-reset control decode.
    always_comb begin
        st_nx        = st;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        pll_release  = 1'b0;
        pll_reassert = 1'b0;
        done_set     = 1'b0;
        unique case (st)
            ST_IDLE, ST_ERR: begin
                if (start_req) begin
                    if (!int_pll_sel) begin
                        st_nx    = ST_FAST;
                        tmr_load = 1'b1;
                        tmr_val  = fast_ld;
                    end else if (pll_programmed) begin
                        st_nx       = ST_PLLWAIT;
                        tmr_load    = 1'b1;
                        tmr_val     = TMR_W'(LOCK_TO - 1);
                        pll_release = 1'b1;
                    end else begin
                        st_nx = ST_ERR;
                    end
                end else if (flush_req) begin
                    st_nx    = ST_FLUSH;
                    tmr_load = 1'b1;
                    tmr_val  = flush_ld;
                end
            end
            ST_PLLWAIT: begin
                if (pll_lock) begin
                    st_nx    = ST_FAST;
                    tmr_load = 1'b1;
                    tmr_val  = fast_ld;
                end else if (tmr_zero) begin
                    st_nx        = ST_ERR;
                    pll_reassert = 1'b1;
                end
            end
            ST_FAST: begin
                if (tmr_zero) begin
                    st_nx    = ST_FLUSH;
                    tmr_load = 1'b1;
                    tmr_val  = flush_ld;
                end
            end
            ST_FLUSH: begin
                if (tmr_zero) begin
                    st_nx    = ST_IDLE;
                    done_set = 1'b1;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // PLL reset register: held from reset, released on start, re-asserted on lock timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)            pll_rst <= 1'b1;
        else if (pll_release)  pll_rst <= 1'b0;
        else if (pll_reassert) pll_rst <= 1'b1;
    end

    // Completion pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= done_set;
    end

    // Output decode from the state register.
    always_comb begin
        fast_rst   = (st == ST_FAST);
        core_flush = (st == ST_FLUSH);
        busy       = (st == ST_PLLWAIT) || (st == ST_FAST) || (st == ST_FLUSH);
        err        = (st == ST_ERR);
    end

    AST_FAST_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PLLWAIT && pll_lock) |=> (fast_rst && !pll_rst));               // R1
    AST_FLUSH_FOLLOWS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_rst) |-> core_flush);                                          // R2
    AST_NO_RST_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(fast_rst && core_flush));                                               // R2
    AST_EXT_KEEPS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && start_req && !int_pll_sel) |=> (fast_rst && $stable(pll_rst))); // R3
    AST_UNPROG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && start_req && int_pll_sel && !pll_programmed)
            |=> (err && !busy && $stable(pll_rst)));                              // R4
    AST_FLUSH_ISLAND: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && flush_req && !start_req)
            |=> (core_flush && !fast_rst && $stable(pll_rst)));                   // R5
    AST_LOCK_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PLLWAIT && !pll_lock && tmr_zero) |=> (err && pll_rst));        // R7
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_rst && !tmr_zero && (start_req || flush_req)) |=> fast_rst);        // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                          // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err));                                                // R9
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err && flush_req && !start_req) |=> !err);                               // R10

endmodule

// File: rtl/clkstart_rst_seq.sv
// Top of the clock-start reset sequencer.
// What it does: orders PLL release, lock wait, fast-domain reset and core flush after a
// clock-start request, and runs a core-only flush on a flush request.
// Assumes: DEF_LEN fits in LEN_W bits and is at least 1; LOCK_TO is at least 1.
module clkstart_rst_seq #(
    parameter int LEN_W   = 8,
    parameter int DEF_LEN = 16,
    parameter int LOCK_TO = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_pll_sel,
    input  logic             pll_programmed,
    input  logic             pll_lock,
    input  logic             start_req,
    input  logic             flush_req,
    input  logic [LEN_W-1:0] fast_len,
    input  logic [LEN_W-1:0] flush_len,
    output logic             pll_rst,
    output logic             fast_rst,
    output logic             core_flush,
    output logic             busy,
    output logic             err,
    output logic             done
);

    localparam int LOCK_W = $clog2(LOCK_TO + 1);
    localparam int TMR_W  = (LEN_W > LOCK_W) ? LEN_W : LOCK_W;

    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;

    seq_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    seq_ctrl #(
        .LEN_W   (LEN_W),
        .DEF_LEN (DEF_LEN),
        .LOCK_TO (LOCK_TO),
        .TMR_W   (TMR_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .int_pll_sel    (int_pll_sel),
        .pll_programmed (pll_programmed),
        .pll_lock       (pll_lock),
        .start_req      (start_req),
        .flush_req      (flush_req),
        .fast_len       (fast_len),
        .flush_len      (flush_len),
        .tmr_zero       (tmr_zero),
        .tmr_load       (tmr_load),
        .tmr_val        (tmr_val),
        .pll_rst        (pll_rst),
        .fast_rst       (fast_rst),
        .core_flush     (core_flush),
        .busy           (busy),
        .err            (err),
        .done           (done)
    );

endmodule

// File: tb/tb_clkstart_rst_seq.sv
// Directed bench for the clock-start reset sequencer: one task per scenario.
module tb_clkstart_rst_seq;

    localparam int LEN_W   = 8;
    localparam int DEF_LEN = 16;
    localparam int LOCK_TO = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             int_pll_sel = 1'b0, pll_programmed = 1'b0, pll_lock = 1'b0;
    logic             start_req = 1'b0, flush_req = 1'b0;
    logic [LEN_W-1:0] fast_len = '0, flush_len = '0;
    logic             pll_rst, fast_rst, core_flush, busy, err, done;

    int tests = 0;
    int fails = 0;

    clkstart_rst_seq #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN), .LOCK_TO(LOCK_TO)) dut (
        .clk(clk), .rst_n(rst_n), .int_pll_sel(int_pll_sel), .pll_programmed(pll_programmed),
        .pll_lock(pll_lock), .start_req(start_req), .flush_req(flush_req),
        .fast_len(fast_len), .flush_len(flush_len), .pll_rst(pll_rst), .fast_rst(fast_rst),
        .core_flush(core_flush), .busy(busy), .err(err), .done(done)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk) flush_req = 1'b1;
        @(negedge clk) flush_req = 1'b0;
    endtask

    task automatic count_fast(output int n);
        n = 0;
        while (fast_rst === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic count_flush(output int n);
        n = 0;
        while (core_flush === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic count_wait(output int n);
        n = 0;
        while (busy === 1'b1 && err === 1'b0 && fast_rst === 1'b0 && n < 1000) begin
            n++; @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "pll_rst", pll_rst, 1);
        check("R11", "fast/flush/busy/err/done", {fast_rst, core_flush, busy, err, done}, 0);
    endtask

    task automatic t_ext_default();
        int n;
        int_pll_sel = 1'b0; fast_len = '0; flush_len = 8'd5;
        pulse_start();
        check("R3", "fast_rst next cycle", fast_rst, 1);
        check("R3", "pll_rst kept", pll_rst, 1);
        count_fast(n);
        check("R6", "default fast length", n, DEF_LEN);
        check("R2", "flush follows fast", core_flush, 1);
        count_flush(n);
        check("R6", "explicit flush length", n, 5);
        check("R3", "pll_rst still kept", pll_rst, 1);
        check("R9", "done after flush", done, 1);
        check("R9", "busy low at done", busy, 0);
        @(negedge clk);
        check("R9", "done one cycle", done, 0);
    endtask

    task automatic t_int_lock();
        int n;
        int_pll_sel = 1'b1; pll_programmed = 1'b1; pll_lock = 1'b0;
        fast_len = 8'd3; flush_len = 8'd2;
        pulse_start();
        check("R1", "pll_rst released", pll_rst, 0);
        check("R1", "busy in lock wait", busy, 1);
        repeat (3) @(negedge clk);
        check("R1", "no fast_rst before lock", fast_rst, 0);
        pll_lock = 1'b1;
        @(negedge clk);
        check("R1", "fast_rst after lock", fast_rst, 1);
        count_fast(n);
        check("R2", "fast length", n, 3);
        count_flush(n);
        check("R2", "flush length", n, 2);
        check("R9", "done after int seq", done, 1);
    endtask

    task automatic t_flush_only();
        int n;
        int prev_pll;
        flush_len = 8'd3;
        prev_pll = int'(pll_rst);
        pulse_flush();
        check("R5", "core_flush raised", core_flush, 1);
        check("R5", "fast_rst untouched", fast_rst, 0);
        count_flush(n);
        check("R5", "flush-only length", n, 3);
        check("R5", "pll_rst untouched", pll_rst, prev_pll);
        check("R9", "done after flush-only", done, 1);
    endtask

    task automatic t_ignore_busy();
        int n;
        int_pll_sel = 1'b0; fast_len = 8'd4; flush_len = 8'd4;
        pulse_start();
        @(negedge clk) begin start_req = 1'b1; flush_req = 1'b1; end
        @(negedge clk) begin start_req = 1'b0; flush_req = 1'b0; end
        count_fast(n);
        check("R8", "fast remainder unchanged", n, 2);
        count_flush(n);
        check("R8", "flush length unchanged", n, 4);
        repeat (5) @(negedge clk);
        check("R8", "nothing restarted", {busy, fast_rst, core_flush}, 0);
    endtask

    task automatic t_unprog();
        int n;
        int prev_pll;
        int_pll_sel = 1'b1; pll_programmed = 1'b0;
        prev_pll = int'(pll_rst);
        pulse_start();
        check("R4", "err raised", err, 1);
        check("R4", "no reset outputs", {busy, fast_rst, core_flush}, 0);
        check("R4", "pll_rst unchanged", pll_rst, prev_pll);
        flush_len = 8'd2;
        pulse_flush();
        check("R10", "err cleared by flush", err, 0);
        check("R10", "flush accepted in err", core_flush, 1);
        count_flush(n);
        check("R10", "flush length from err", n, 2);
        // start and flush together from idle: the start wins
        int_pll_sel = 1'b0; fast_len = 8'd2;
        @(negedge clk) begin start_req = 1'b1; flush_req = 1'b1; end
        @(negedge clk) begin start_req = 1'b0; flush_req = 1'b0; end
        check("R10", "start wins over flush", fast_rst, 1);
        count_fast(n);
        count_flush(n);
    endtask

    task automatic t_timeout();
        int n;
        int_pll_sel = 1'b1; pll_programmed = 1'b1; pll_lock = 1'b0;
        pulse_start();
        count_wait(n);
        check("R7", "lock wait cycles", n, LOCK_TO);
        check("R7", "err after timeout", err, 1);
        check("R7", "pll_rst reasserted", pll_rst, 1);
        check("R7", "busy low", busy, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_ext_default();
        t_int_lock();
        t_flush_only();
        t_ignore_busy();
        t_unprog();
        t_timeout();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule